// File: doc/BRIEF.md
# Gaussian Mixture Log-Domain Component Scorer

This block takes one 12-element feature vector and scores it against every component of a diagonal-covariance Gaussian mixture, all in the log domain. For each component it forms a squared distance to that component's mean, weighted element by element by the inverse variance. It then adds the component's precomputed log constant. After all components are scored, it emits the scores as a stream, each with the largest score subtracted, so that the stream is ready for an exponent stage performing a log-sum-exp.

Component parameters (mean vector, inverse-variance vector, log constant) are written into a local register file before scoring. A start pulse then latches the feature vector. The block works through the components one element per clock through a three-stage pipeline: subtract, square, weight and accumulate. Finished component scores go into an M-entry buffer while a running maximum is kept. The buffer is then drained one beat per clock. Samples are 16-bit two's complement with 14 fractional bits.

Top module: `gmm_lse_scorer`

## Requirements
- R1: A cycle with `prm_we` high stores `prm_mean`, `prm_ivar` (element e in bits [16e+15:16e]) and `prm_logk` for component `prm_idx`. The stored values persist, across reset as well, until they are overwritten.
- R2: A `start` while `busy` is low latches `feat` (element e in bits [16e+15:16e]), and `busy` is high after that edge. A `start` while `busy` is high is ignored.
- R3: For each element, the difference feature minus mean is clipped to the 16-bit signed range. Its square, shifted right 14 bits, is clipped. That value times the inverse variance, arithmetically shifted right 14 bits, is clipped.
- R4: The D weighted terms of a component are summed from zero with clipping after every addition. The component score is the clipped sum plus the component's log constant.
- R5: The block emits exactly M beats in component order 0..M-1, on consecutive cycles. Beat i carries score i minus the largest score, clipped to 16 bits, so no beat is positive.
- R6: The first beat is visible after the (D*M+4)th rising edge, counting the edge that accepts `start` as edge 0.
- R7: `out_last` is high on beat M-1 only. `out_valid` and `out_last` are low outside the M beats.
- R8: `busy` stays high through the last beat and is low on the cycle after it.
- R9: A synchronous active-low reset clears `busy`, `out_valid` and `out_last` and abandons any run in progress, so no beats follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prm_we | input | 1 | Write one component's parameters |
| prm_idx | input | CW | Component index for the write |
| prm_mean | input | D*16 | Mean vector, packed |
| prm_ivar | input | D*16 | Inverse-variance vector, packed |
| prm_logk | input | 16 | Per-component log constant |
| start | input | 1 | Begin scoring `feat` |
| feat | input | D*16 | Feature vector, packed |
| busy | output | 1 | Run in progress |
| out_valid | output | 1 | Normalised score beat valid |
| out_data | output | 16 | Score minus maximum |
| out_last | output | 1 | Marks the final beat |

## Verification
Every result is tied to the edge that accepts `start`. `busy` is due one edge later. The first normalised beat is due D*M+4 edges later, the rest follow one per edge, and `busy` falls one edge after the last beat. The bench drives inputs and samples outputs on falling edges. It counts edges from the accepting edge, records the index at which each beat appears, and compares that index with the expected cycle as well as the value with a model computed in the bench. The reset test counts for the full run length after an abort to show that no stray beat arrives.

// File: rtl/gmm_lse_pkg.sv
// Shared sample types and clipping helpers for the mixture scorer.
// Assumes Q2.14 signed samples; a wide intermediate covers every product.
package gmm_lse_pkg;
    localparam int SW   = 16;
    localparam int FRAC = 14;
    localparam int XW   = 40;

    typedef logic signed [SW-1:0] samp_t;
    typedef logic signed [XW-1:0] wide_t;

    localparam wide_t WMAX = 40'sd32767;
    localparam wide_t WMIN = -40'sd32768;

    // Sign-extend a sample into the wide domain.
    function automatic wide_t widen(input samp_t v);
        return {{(XW-SW){v[SW-1]}}, v};
    endfunction

    // Clip a wide value into the signed sample range.
    function automatic samp_t clip(input wide_t v);
        if (v > WMAX) return samp_t'(WMAX[SW-1:0]);
        if (v < WMIN) return samp_t'(WMIN[SW-1:0]);
        return v[SW-1:0];
    endfunction
endpackage

// File: rtl/gmm_param_store.sv
// Register file holding mean, inverse variance and log constant per component.
// One write port loads a whole component; two combinational read ports serve
// the distance pipeline (per element) and the normaliser (log constant).
// Storage is deliberately not reset so that loaded models survive a reset.
module gmm_param_store
    import gmm_lse_pkg::*;
#(
    parameter int D  = 12,
    parameter int M  = 20,
    parameter int CW = 5,
    parameter int EW = 4
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [CW-1:0]   wr_idx,
    input  logic [D*SW-1:0] wr_mean,
    input  logic [D*SW-1:0] wr_ivar,
    input  logic [SW-1:0]   wr_logk,
    input  logic [CW-1:0]   rd_comp,
    input  logic [EW-1:0]   rd_elem,
    output samp_t           rd_mean,
    output samp_t           rd_ivar,
    input  logic [CW-1:0]   lk_comp,
    output samp_t           rd_logk
);
    samp_t mean_q [M][D];
    samp_t ivar_q [M][D];
    samp_t logk_q [M];

    // Load every field of the addressed component in one cycle.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int e = 0; e < D; e++) begin
                mean_q[wr_idx][e] <= wr_mean[e*SW +: SW];
                ivar_q[wr_idx][e] <= wr_ivar[e*SW +: SW];
            end
            logk_q[wr_idx] <= wr_logk;
        end
    end

    // Combinational read ports.
    always_comb begin
        rd_mean = mean_q[rd_comp][rd_elem];
        rd_ivar = ivar_q[rd_comp][rd_elem];
        rd_logk = logk_q[lk_comp];
    end
endmodule

// File: rtl/gmm_dist_pipe.sv
// Three-stage element-serial weighted distance pipeline.
// Stage 1 subtracts the mean, stage 2 squares, stage 3 weights by the
// inverse variance and accumulates. Every step clips to 16 bits.
// Assumes elements of one component arrive on consecutive cycles,
// flagged first and last.
module gmm_dist_pipe
    import gmm_lse_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic          in_first,
    input  logic          in_last,
    input  logic [CW-1:0] in_comp,
    input  samp_t         in_x,
    input  samp_t         in_mu,
    input  samp_t         in_iv,
    output logic          out_vld,
    output logic [CW-1:0] out_comp,
    output samp_t         out_acc
);
    logic          s1_vld, s1_first, s1_last;
    logic [CW-1:0] s1_comp;
    samp_t         s1_diff, s1_iv;
    logic          s2_vld, s2_first, s2_last;
    logic [CW-1:0] s2_comp;
    samp_t         s2_sq, s2_iv;
    wide_t         sq_w, term_w;
    samp_t         term;

    // Products are formed in the wide domain, then scaled and clipped.
    always_comb begin
        sq_w   = (widen(s1_diff) * widen(s1_diff)) >>> FRAC;
        term_w = (widen(s2_sq) * widen(s2_iv)) >>> FRAC;
        term   = clip(term_w);
    end

    // Stage 1: clipped difference between feature and mean.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0; s1_first <= 1'b0; s1_last <= 1'b0;
            s1_comp <= '0; s1_diff <= '0; s1_iv <= '0;
        end else begin
            s1_vld   <= in_vld;
            s1_first <= in_first;
            s1_last  <= in_last;
            s1_comp  <= in_comp;
            s1_diff  <= clip(widen(in_x) - widen(in_mu));
            s1_iv    <= in_iv;
        end
    end

    // Stage 2: clipped square of the difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld <= 1'b0; s2_first <= 1'b0; s2_last <= 1'b0;
            s2_comp <= '0; s2_sq <= '0; s2_iv <= '0;
        end else begin
            s2_vld   <= s1_vld;
            s2_first <= s1_first;
            s2_last  <= s1_last;
            s2_comp  <= s1_comp;
            s2_sq    <= clip(sq_w);
            s2_iv    <= s1_iv;
        end
    end

    // Stage 3: weighted term into the clipping accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_acc <= '0; out_vld <= 1'b0; out_comp <= '0;
        end else begin
            out_vld  <= s2_vld && s2_last;
            out_comp <= s2_comp;
            if (s2_vld)
                out_acc <= s2_first ? term : clip(widen(out_acc) + widen(term));
        end
    end
endmodule

// File: rtl/gmm_lse_norm.sv
// Adds the log constant to each finished component score, buffers the
// scores, tracks their maximum and then drains score minus maximum.
// Assumes scores arrive in component order 0..M-1.
module gmm_lse_norm
    import gmm_lse_pkg::*;
#(
    parameter int M  = 20,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_vld,
    input  logic [CW-1:0] wr_comp,
    input  samp_t         wr_acc,
    input  samp_t         wr_logk,
    output logic          out_valid,
    output samp_t         out_data,
    output logic          out_last
);
    localparam logic [CW-1:0] LAST_C = CW'(M-1);

    samp_t         buf_q [M];
    samp_t         max_q;
    samp_t         score;
    logic          drain_q;
    logic [CW-1:0] rd_idx;

    // Offset score for the incoming component.
    always_comb score = clip(widen(wr_acc) + widen(wr_logk));

    // Buffer write and running maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q <= '0;
        end else if (wr_vld) begin
            buf_q[wr_comp] <= score;
            if (wr_comp == '0 || score > max_q)
                max_q <= score;
        end
    end

    // Drain sequencer: one normalised beat per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drain_q <= 1'b0; rd_idx <= '0;
            out_valid <= 1'b0; out_last <= 1'b0; out_data <= '0;
        end else begin
            if (wr_vld && wr_comp == LAST_C) begin
                drain_q <= 1'b1;
                rd_idx  <= '0;
            end else if (drain_q) begin
                rd_idx <= rd_idx + 1'b1;
                if (rd_idx == LAST_C) drain_q <= 1'b0;
            end
            out_valid <= drain_q;
            out_last  <= drain_q && rd_idx == LAST_C;
            if (drain_q) out_data <= clip(widen(buf_q[rd_idx]) - widen(max_q));
        end
    end
endmodule

// File: rtl/gmm_lse_scorer.sv
// Top of the log-domain mixture scorer. Latches a feature vector on start,
// issues one (component, element) pair per clock to the distance pipeline,
// and hands finished scores to the normaliser. Assumes parameters are only
// written while busy is low.
module gmm_lse_scorer
    import gmm_lse_pkg::*;
#(
    parameter int D = 12,
    parameter int M = 20,
    localparam int CW = (M > 1) ? $clog2(M) : 1,
    localparam int PW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prm_we,
    input  logic [CW-1:0]   prm_idx,
    input  logic [D*PW-1:0] prm_mean,
    input  logic [D*PW-1:0] prm_ivar,
    input  logic [PW-1:0]   prm_logk,
    input  logic            start,
    input  logic [D*PW-1:0] feat,
    output logic            busy,
    output logic            out_valid,
    output logic [PW-1:0]   out_data,
    output logic            out_last
);
    localparam int EW = (D > 1) ? $clog2(D) : 1;
    localparam logic [CW-1:0] LAST_C = CW'(M-1);
    localparam logic [EW-1:0] LAST_E = EW'(D-1);

    samp_t         feat_q [D];
    logic          issuing;
    logic [CW-1:0] comp_cnt;
    logic [EW-1:0] elem_cnt;
    samp_t         cur_mean, cur_ivar, done_logk, done_acc, norm_data;
    logic          done_vld;
    logic [CW-1:0] done_comp;

    // Run control: accept start, walk components and elements, end on last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; issuing <= 1'b0; comp_cnt <= '0; elem_cnt <= '0;
            for (int e = 0; e < D; e++) feat_q[e] <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1; issuing <= 1'b1; comp_cnt <= '0; elem_cnt <= '0;
            for (int e = 0; e < D; e++) feat_q[e] <= feat[e*PW +: PW];
        end else begin
            if (issuing) begin
                if (elem_cnt == LAST_E) begin
                    elem_cnt <= '0;
                    if (comp_cnt == LAST_C) issuing <= 1'b0;
                    else comp_cnt <= comp_cnt + 1'b1;
                end else begin
                    elem_cnt <= elem_cnt + 1'b1;
                end
            end
            if (out_last) busy <= 1'b0;
        end
    end

    gmm_param_store #(.D(D), .M(M), .CW(CW), .EW(EW)) u_store (
        .clk(clk), .wr_en(prm_we), .wr_idx(prm_idx),
        .wr_mean(prm_mean), .wr_ivar(prm_ivar), .wr_logk(prm_logk),
        .rd_comp(comp_cnt), .rd_elem(elem_cnt),
        .rd_mean(cur_mean), .rd_ivar(cur_ivar),
        .lk_comp(done_comp), .rd_logk(done_logk)
    );

    gmm_dist_pipe #(.CW(CW)) u_pipe (
        .clk(clk), .rst_n(rst_n), .in_vld(issuing),
        .in_first(elem_cnt == '0), .in_last(elem_cnt == LAST_E),
        .in_comp(comp_cnt), .in_x(feat_q[elem_cnt]),
        .in_mu(cur_mean), .in_iv(cur_ivar),
        .out_vld(done_vld), .out_comp(done_comp), .out_acc(done_acc)
    );

    gmm_lse_norm #(.M(M), .CW(CW)) u_norm (
        .clk(clk), .rst_n(rst_n), .wr_vld(done_vld), .wr_comp(done_comp),
        .wr_acc(done_acc), .wr_logk(done_logk),
        .out_valid(out_valid), .out_data(norm_data), .out_last(out_last)
    );

    assign out_data = norm_data;
endmodule

// File: rtl/gmm_lse_scorer_chk.sv
// Protocol checker for the mixture scorer, bound onto every instance.
module gmm_lse_scorer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        out_valid,
    input logic [15:0] out_data,
    input logic        out_last
);
    // R2: an accepted start makes the block busy on the next cycle.
    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R7: the last flag only rides on a valid beat.
    a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    // R7: beats only appear during a run.
    a_r7_valid_within_run: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
    // R5: normalised scores are never above the maximum.
    a_r5_nonpositive: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(out_data) <= 0));
    // R8: the run ends on the cycle after the last beat.
    a_r8_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !busy);
    // R8: busy only drops right after a last beat.
    a_r8_fall_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(out_last));
endmodule

bind gmm_lse_scorer gmm_lse_scorer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
);

// File: tb/gmm_lse_scorer_bench.sv
module gmm_lse_scorer_bench;
    import gmm_lse_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int D = 12;
    localparam int M = 20;
    localparam int CW = 5;
    localparam int NCASE = 5;
    localparam int FIRST_BEAT = D*M + 4;
    localparam int RUN_LIMIT = D*M + M + 20;
    localparam int WATCHDOG = 100000;

    // Stimulus table: generator seed, saturation mode, stray start during run.
    localparam logic [15:0] CASE_SEED [NCASE] = '{16'd3, 16'd91, 16'd517, 16'd2024, 16'd7};
    localparam logic        CASE_SAT  [NCASE] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    localparam logic        CASE_POKE [NCASE] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            prm_we = 1'b0;
    logic [CW-1:0]   prm_idx = '0;
    logic [D*16-1:0] prm_mean = '0, prm_ivar = '0;
    logic [15:0]     prm_logk = '0;
    logic            start = 1'b0;
    logic [D*16-1:0] feat = '0;
    logic            busy, out_valid, out_last;
    logic [15:0]     out_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    samp_t mu_m [M][D];
    samp_t iv_m [M][D];
    samp_t lk_m [M];
    samp_t x_m  [D];
    samp_t exp_m [M];

    always #(CLK_PERIOD/2) clk = ~clk;

    gmm_lse_scorer #(.D(D), .M(M)) u_gmm_lse_scorer (
        .clk(clk), .rst_n(rst_n), .prm_we(prm_we), .prm_idx(prm_idx),
        .prm_mean(prm_mean), .prm_ivar(prm_ivar), .prm_logk(prm_logk),
        .start(start), .feat(feat), .busy(busy), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last)
    );

    function automatic samp_t bsat(input longint v);
        if (v > 32767) return 16'sh7FFF;
        if (v < -32768) return 16'sh8000;
        return samp_t'(v[15:0]);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
        $finish;
    endtask

    // Build one case's model data and the expected normalised beats (R3, R4, R5).
    task automatic build_case(input logic [15:0] seed, input logic sat);
        longint acc, d, s, t, mx;
        samp_t sc [M];
        for (int e = 0; e < D; e++)
            x_m[e] = sat ? 16'sh7FFF : samp_t'(((int'(seed)*7 + e*1234) & 'h3FFF) - 'h2000);
        for (int c = 0; c < M; c++) begin
            for (int e = 0; e < D; e++) begin
                mu_m[c][e] = sat ? 16'sh8000 :
                    samp_t'(((int'(seed)*(c+3) + e*977 + c*131) & 'h3FFF) - 'h2000);
                iv_m[c][e] = sat ? 16'sh7FFF :
                    samp_t'('h1000 + ((c*37 + e*11 + int'(seed)) & 'h0FFF));
            end
            lk_m[c] = samp_t'(((int'(seed) ^ (c*523)) & 'h0FFF) - 'h0800);
        end
        for (int c = 0; c < M; c++) begin
            acc = 0;
            for (int e = 0; e < D; e++) begin
                d = bsat(longint'(x_m[e]) - longint'(mu_m[c][e]));
                s = bsat((d*d) >>> 14);
                t = bsat((s*longint'(iv_m[c][e])) >>> 14);
                acc = (e == 0) ? t : bsat(acc + t);
            end
            sc[c] = bsat(acc + longint'(lk_m[c]));
        end
        mx = sc[0];
        for (int c = 1; c < M; c++) if (sc[c] > mx) mx = sc[c];
        for (int c = 0; c < M; c++) exp_m[c] = bsat(longint'(sc[c]) - mx);
    endtask

    task automatic load_params();
        for (int c = 0; c < M; c++) begin
            @(negedge clk);
            prm_we = 1'b1;
            prm_idx = CW'(c);
            for (int e = 0; e < D; e++) begin
                prm_mean[e*16 +: 16] = mu_m[c][e];
                prm_ivar[e*16 +: 16] = iv_m[c][e];
            end
            prm_logk = lk_m[c];
        end
        @(negedge clk);
        prm_we = 1'b0;
    endtask

    // Start a run and check every beat, its cycle and the end of the run.
    task automatic run_case(input bit poke);
        int beats, first_n, last_n;
        logic [D*16-1:0] fv;
        for (int e = 0; e < D; e++) fv[e*16 +: 16] = x_m[e];
        @(negedge clk);
        feat = fv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
        beats = 0; first_n = -1; last_n = -1;
        for (int n = 1; n < RUN_LIMIT; n++) begin
            @(negedge clk);
            if (out_valid) begin
                if (beats == 0) first_n = n;
                if (beats < M)
                    chk($signed(out_data) == exp_m[beats], "R3/R4/R5 beat value",
                        longint'($signed(out_data)), longint'(exp_m[beats]));
                chk(out_last == (beats == M-1), "R7 last flag",
                    longint'(out_last), longint'(beats == M-1));
                if (out_last) begin
                    last_n = n;
                    chk(busy == 1'b1, "R8 busy on last beat", longint'(busy), 1);
                end
                beats++;
            end else begin
                chk(out_last == 1'b0, "R7 last without valid", longint'(out_last), 0);
            end
            if (last_n > 0 && n == last_n + 1)
                chk(busy == 1'b0, "R8 idle after last", longint'(busy), 0);
            if (poke && n == 5) begin
                feat = ~fv;
                start = 1'b1;
            end
            if (poke && n == 6) begin
                start = 1'b0;
                feat = fv;
            end
        end
        chk(first_n == FIRST_BEAT, "R6 first beat cycle", first_n, FIRST_BEAT);
        chk(beats == M, "R5 beat count", beats, M);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && out_valid == 1'b0, "R9 outputs in reset", longint'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R9 busy after reset", longint'(busy), 0);
        chk(out_valid == 1'b0 && out_last == 1'b0, "R9 beats after reset",
            longint'(out_valid), 0);

        // Table walk: R1 reloads, R2 stray start in one case, R3 saturation in one case.
        for (int k = 0; k < NCASE; k++) begin
            build_case(CASE_SEED[k], CASE_SAT[k]);
            load_params();
            run_case(CASE_POKE[k]);
        end

        // R9: abort a run with reset, then confirm no beats follow.
        build_case(CASE_SEED[1], 1'b0);
        load_params();
        @(negedge clk);
        for (int e = 0; e < D; e++) feat[e*16 +: 16] = x_m[e];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0 && out_valid == 1'b0, "R9 abort clears", longint'(busy), 0);
        rst_n = 1'b1;
        begin
            int stray;
            stray = 0;
            for (int n = 0; n < RUN_LIMIT; n++) begin
                @(negedge clk);
                if (out_valid || busy) stray++;
            end
            chk(stray == 0, "R9 no beats after abort", stray, 0);
        end

        // R1: parameters survive reset; rerun without reloading.
        run_case(1'b0);

        summary();
    end
endmodule